// File: doc/BRIEF.md
# Byte-Serial Register Target with 24-bit Words

This block is the target side of an I2C bus that exposes a small map of 24-bit registers to a bus controller. SCL and SDA arrive as oversampled logic levels on a system clock that runs at least sixteen times faster than SCL. The block answers only to a 7-bit device address built from a fixed high part and a 4-bit strap value, and it signals on SDA only through a pull-low enable.

A controller writes by sending a register index byte and then data in groups of three bytes, most significant first. Each full group commits one whole word and moves the index up by one. Reads use the combined format: an index write, a repeated START, then three bytes per word for as long as the controller keeps acknowledging. One word reports status from the surrounding logic: current sample, live fault, latched fault and a new-data flag. Three words hold control fields that drive outputs. One-cycle pulses tell the surrounding logic to clear the latched fault and the new-data flag.

Top module: `i2c24_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {3'b110, strap_i}. Any other address gets a NACK, and the block ignores the bus until the next START.
- R2: A write is: address with R/W=0, one index byte, then data bytes. The block ACKs every byte. A word commits to its register only once its third data byte has been acknowledged. The first byte carries bits 23:16 and the last carries bits 7:0.
- R3: In a write that continues without a STOP, each further complete three-byte group goes to the previous index plus one.
- R4: A trailing group of fewer than three data bytes is dropped and never written, whether a STOP or a START ends it.
- R5: After an index write and a repeated START with R/W=1, the block returns three bytes per word, MSB first. A controller ACK after the third byte continues at index plus one. A controller NACK ends the read, and SDA is released.
- R6: Index 0x00 reads as {12'b0, fault_now_i, fault_lat_i, sync_i, cur_i[8:0]}. Index 0x02 holds avg_o in bits 7:0, index 0x04 holds gain_o in bits 1:0, and index 0x06 holds flevel_o in bits 3:0. All other bits of these words read 0.
- R7: Every index outside 0x00, 0x02, 0x04 and 0x06 reads 0 and ignores writes, and its bytes are still acknowledged.
- R8: A committed write to index 0x00 with bit 10 set gives exactly one one-cycle pulse on lat_clr_o. With bit 10 clear it gives no pulse. A write to index 0x00 never changes the control outputs.
- R9: Each three-byte read group taken from index 0x00 gives exactly one one-cycle pulse on sync_clr_o. A read from any other index gives none.
- R10: After reset, sda_pull_o is 0, avg_o is 0, flevel_o is 0 and gain_o equals the GAIN_RST parameter (0 or 3).
- R11: A START at any point aborts the transfer in progress and begins a new address byte.
- R12: sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (wired bus value) |
| strap_i | input | 4 | Low four bits of the device address |
| cur_i | input | 9 | Current sample shown in the status word |
| fault_now_i | input | 1 | Live overcurrent flag |
| fault_lat_i | input | 1 | Latched overcurrent flag |
| sync_i | input | 1 | New-data flag |
| sda_pull_o | output | 1 | When 1, SDA is pulled low |
| avg_o | output | 8 | Averaging count control field |
| gain_o | output | 2 | Range select: 00=32 A, 01=64 A, 10=8 A, 11=16 A |
| flevel_o | output | 4 | Fault threshold select |
| lat_clr_o | output | 1 | One-cycle pulse: clear the latched fault |
| sync_clr_o | output | 1 | One-cycle pulse: clear the new-data flag |

## Verification
The hardest case to reach is a data group cut short in the middle of a stream. The index has already moved on, and the next START or STOP must drop the partial bytes without moving any field. The stimulus streams one ignored group to an unmapped index, then one full group and two extra bytes. In a separate transfer, a repeated START arrives after a single data byte. The bench then reads the fields back through the bus and also watches them at the outputs. A continued read that crosses from an unmapped index into a mapped one checks that the pointer steps on the third acknowledged byte.

// File: rtl/i2c24_pkg.sv
package i2c24_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_REG, PH_WR, PH_RD} phase_t;
endpackage

// File: rtl/i2c24_sync.sv
module i2c24_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  logic scl_c, scl_p, sda_p;
  assign scl_c     = scl_sh[STAGES-1];
  assign scl_p     = scl_sh[STAGES];
  assign sda_s     = sda_sh[STAGES-1];
  assign sda_p     = sda_sh[STAGES];
  assign scl_rise  = scl_c & ~scl_p;
  assign scl_fall  = ~scl_c & scl_p;
  assign start_det = scl_c & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_c & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c24_engine.sv
module i2c24_engine
  import i2c24_pkg::*;
#(
  parameter int         REG_BYTES = 3,
  parameter int         STRAP_W   = 4,
  parameter logic [2:0] DEV_HI    = 3'b110
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scl_rise,
  input  logic                          scl_fall,
  input  logic                          sda_s,
  input  logic                          start_det,
  input  logic                          stop_det,
  input  logic [STRAP_W-1:0]            strap,
  input  logic [REG_BYTES*BYTE_W-1:0]   rd_word,
  output logic [BYTE_W-1:0]             rd_addr,
  output logic [BYTE_W-1:0]             ptr,
  output logic                          rd_load,
  output logic                          wr_en,
  output logic [BYTE_W-1:0]             wr_addr,
  output logic [REG_BYTES*BYTE_W-1:0]   wr_word,
  output logic                          sda_pull
);
  localparam int REG_W = REG_BYTES * BYTE_W;
  localparam int GRP_W = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;
  localparam int IDX_W = $clog2(REG_W);
  localparam logic [GRP_W-1:0] LAST = GRP_W'(REG_BYTES - 1);

  phase_t            ph;
  logic [BYTE_W-1:0] sr;
  logic [3:0]        bitcnt;
  logic              in_ack, rw, mack;
  logic [GRP_W-1:0]  grp;
  logic [REG_W-1:0]  shadow, wbuf;
  logic              dev_match, step_grp;
  logic [IDX_W-1:0]  tx_idx;

  assign dev_match = (sr[7:1] == {DEV_HI, strap});
  assign step_grp  = (ph == PH_RD) && in_ack && (grp == LAST);
  assign rd_addr   = step_grp ? ptr + 1'b1 : ptr;
  assign tx_idx    = IDX_W'(REG_W - 1) - IDX_W'(bitcnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; sr <= '0; bitcnt <= '0; in_ack <= 1'b0; rw <= 1'b0;
      mack <= 1'b1; grp <= '0; shadow <= '0; wbuf <= '0; ptr <= '0;
      rd_load <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_word <= '0;
      sda_pull <= 1'b0;
    end else begin
      rd_load <= 1'b0;
      wr_en   <= 1'b0;
      if (start_det) begin
        ph <= PH_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0; grp <= '0;
      end else if (stop_det) begin
        ph <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0; grp <= '0;
      end else begin
        case (ph)
          PH_DEV, PH_REG, PH_WR: begin
            if (scl_rise && !in_ack && bitcnt != 4'd8) begin
              sr     <= {sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && !in_ack && bitcnt == 4'd8) begin
              if (ph == PH_DEV && !dev_match) begin
                ph <= PH_IDLE;
              end else begin
                sda_pull <= 1'b1;
                in_ack   <= 1'b1;
              end
              if (ph == PH_DEV) rw <= sr[0];
              if (ph == PH_REG) begin ptr <= sr; grp <= '0; end
              if (ph == PH_WR)  wbuf <= {wbuf[REG_W-BYTE_W-1:0], sr};
            end else if (scl_fall && in_ack) begin
              sda_pull <= 1'b0;
              in_ack   <= 1'b0;
              bitcnt   <= '0;
              case (ph)
                PH_DEV: begin
                  if (rw) begin
                    ph       <= PH_RD;
                    grp      <= '0;
                    shadow   <= rd_word;
                    rd_load  <= 1'b1;
                    sda_pull <= ~rd_word[REG_W-1];
                  end else begin
                    ph <= PH_REG;
                  end
                end
                PH_REG: ph <= PH_WR;
                default: begin
                  if (grp == LAST) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_word <= wbuf;
                    ptr     <= ptr + 1'b1;
                    grp     <= '0;
                  end else begin
                    grp <= grp + 1'b1;
                  end
                end
              endcase
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              if (in_ack) mack <= sda_s;
              else        bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && !in_ack) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                in_ack   <= 1'b1;
              end else begin
                sda_pull <= ~shadow[tx_idx];
              end
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              if (mack) begin
                ph       <= PH_IDLE;
                sda_pull <= 1'b0;
              end else if (grp == LAST) begin
                grp      <= '0;
                ptr      <= rd_addr;
                shadow   <= rd_word;
                rd_load  <= 1'b1;
                sda_pull <= ~rd_word[REG_W-1];
              end else begin
                grp      <= grp + 1'b1;
                shadow   <= shadow << BYTE_W;
                sda_pull <= ~shadow[REG_W-BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c24_regs.sv
module i2c24_regs #(
  parameter int         REG_W    = 24,
  parameter int         CUR_W    = 9,
  parameter int         AVG_W    = 8,
  parameter int         GAIN_W   = 2,
  parameter int         FLT_W    = 4,
  parameter int         LAT_BIT  = 10,
  parameter logic [7:0] ADR_STAT = 8'h00,
  parameter logic [7:0] ADR_AVG  = 8'h02,
  parameter logic [7:0] ADR_GAIN = 8'h04,
  parameter logic [7:0] ADR_FLT  = 8'h06,
  parameter int         GAIN_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_word,
  input  logic [7:0]        rd_addr,
  input  logic              rd_load,
  input  logic [7:0]        rd_ptr,
  input  logic [CUR_W-1:0]  cur,
  input  logic              fault_now,
  input  logic              fault_lat,
  input  logic              sync_flag,
  output logic [REG_W-1:0]  rd_word,
  output logic [AVG_W-1:0]  avg_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [FLT_W-1:0]  flevel_o,
  output logic              lat_clr_o,
  output logic              sync_clr_o
);
  localparam int STAT_W = CUR_W + 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_o      <= '0;
      gain_o     <= GAIN_W'(GAIN_RST);
      flevel_o   <= '0;
      lat_clr_o  <= 1'b0;
      sync_clr_o <= 1'b0;
    end else begin
      lat_clr_o  <= wr_en && (wr_addr == ADR_STAT) && wr_word[LAT_BIT];
      sync_clr_o <= rd_load && (rd_ptr == ADR_STAT);
      if (wr_en) begin
        if (wr_addr == ADR_AVG)  avg_o    <= wr_word[AVG_W-1:0];
        if (wr_addr == ADR_GAIN) gain_o   <= wr_word[GAIN_W-1:0];
        if (wr_addr == ADR_FLT)  flevel_o <= wr_word[FLT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == ADR_STAT)
      rd_word = REG_W'({fault_now, fault_lat, sync_flag, cur});
    else if (rd_addr == ADR_AVG)
      rd_word = REG_W'(avg_o);
    else if (rd_addr == ADR_GAIN)
      rd_word = REG_W'(gain_o);
    else if (rd_addr == ADR_FLT)
      rd_word = REG_W'(flevel_o);
  end

  logic unused_w;
  assign unused_w = (STAT_W == 0);
endmodule

// File: rtl/i2c24_target.sv
module i2c24_target
  import i2c24_pkg::*;
#(
  parameter int REG_BYTES = 3,
  parameter int STRAP_W   = 4,
  parameter int CUR_W     = 9,
  parameter int AVG_W     = 8,
  parameter int GAIN_W    = 2,
  parameter int FLT_W     = 4,
  parameter int SYNC_STG  = 2,
  parameter int GAIN_RST  = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [CUR_W-1:0]   cur_i,
  input  logic               fault_now_i,
  input  logic               fault_lat_i,
  input  logic               sync_i,
  output logic               sda_pull_o,
  output logic [AVG_W-1:0]   avg_o,
  output logic [GAIN_W-1:0]  gain_o,
  output logic [FLT_W-1:0]   flevel_o,
  output logic               lat_clr_o,
  output logic               sync_clr_o
);
  localparam int REG_W = REG_BYTES * BYTE_W;

  logic scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic [7:0] rd_addr, ptr, wr_addr;
  logic rd_load, wr_en;
  logic [REG_W-1:0] rd_word, wr_word;

  i2c24_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c24_engine #(.REG_BYTES(REG_BYTES), .STRAP_W(STRAP_W)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rd_word(rd_word), .rd_addr(rd_addr), .ptr(ptr),
    .rd_load(rd_load), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_word), .sda_pull(sda_pull_o)
  );

  i2c24_regs #(
    .REG_W(REG_W), .CUR_W(CUR_W), .AVG_W(AVG_W), .GAIN_W(GAIN_W),
    .FLT_W(FLT_W), .GAIN_RST(GAIN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_word), .rd_addr(rd_addr), .rd_load(rd_load),
    .rd_ptr(ptr), .cur(cur_i), .fault_now(fault_now_i),
    .fault_lat(fault_lat_i), .sync_flag(sync_i), .rd_word(rd_word),
    .avg_o(avg_o), .gain_o(gain_o), .flevel_o(flevel_o),
    .lat_clr_o(lat_clr_o), .sync_clr_o(sync_clr_o)
  );
endmodule

// File: rtl/i2c24_target_chk.sv
module i2c24_target_chk #(
  parameter int AVG_W  = 8,
  parameter int GAIN_W = 2,
  parameter int FLT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [AVG_W-1:0]  avg_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic [FLT_W-1:0]  flevel_o,
  input logic              lat_clr_o,
  input logic              sync_clr_o
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> (!scl_i && !$past(scl_i)));  // R12
  AST_LAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lat_clr_o |=> !lat_clr_o);  // R8
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sync_clr_o |=> !sync_clr_o);  // R9
  AST_AVG_COMMIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(avg_o) |-> !scl_i);  // R2
  AST_GAIN_COMMIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_o) |-> !scl_i);  // R2
  AST_FLT_COMMIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(flevel_o) |-> !scl_i);  // R2
endmodule

bind i2c24_target i2c24_target_chk #(
  .AVG_W(AVG_W), .GAIN_W(GAIN_W), .FLT_W(FLT_W)
) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .avg_o(avg_o), .gain_o(gain_o), .flevel_o(flevel_o),
  .lat_clr_o(lat_clr_o), .sync_clr_o(sync_clr_o)
);

// File: tb/i2c24_target_bench.sv
module i2c24_target_bench;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'hD4;  // 0x6A, write
  localparam logic [7:0] AR = 8'hD5;  // 0x6A, read

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic [8:0] cur = '0;
  logic fnow = 1'b0, flat = 1'b0, fsync = 1'b0;
  logic sda_pull, lat_clr, sync_clr;
  logic [7:0] avg; logic [1:0] gain; logic [3:0] flevel;
  wire sda_line = m_sda & ~sda_pull;

  int nchk = 0, nfail = 0, lat_cnt = 0, sync_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #10 clk = ~clk;

  i2c24_target u_i2c24_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .cur_i(cur), .fault_now_i(fnow), .fault_lat_i(flat), .sync_i(fsync),
    .sda_pull_o(sda_pull), .avg_o(avg), .gain_o(gain), .flevel_o(flevel),
    .lat_clr_o(lat_clr), .sync_clr_o(sync_clr)
  );

  always @(negedge clk) begin
    if (lat_clr)  lat_cnt++;
    if (sync_clr) sync_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each byte read from the bus with the queued expectation
  always @(negedge clk) begin
    if (obs_q.size() != 0) begin
      logic [7:0] o;
      o = obs_q.pop_front();
      if (exp_q.size() == 0) chk("R5 unexpected byte", {24'h0, o}, 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), {24'h0, o}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq(); endtask
  task automatic bstop();  m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq(); endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic rbyte(input logic nack);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0;
    end
    m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
    obs_q.push_back(b);
  endtask

  task automatic wack(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    wbyte(b, a);
    chk(tag, {31'h0, a}, {31'h0, exp_ack});
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [23:0] d, input string tag);
    bstart(); wack(AW, 1'b0, tag); wack(idx, 1'b0, tag);
    wack(d[23:16], 1'b0, tag); wack(d[15:8], 1'b0, tag); wack(d[7:0], 1'b0, tag);
    bstop();
  endtask

  // driver: queues expected words, then reads nwords words from idx
  task automatic rd_regs(input logic [7:0] idx, input logic [23:0] e0,
                         input logic [23:0] e1, input int nwords, input string tag);
    bstart(); wack(AW, 1'b0, tag); wack(idx, 1'b0, tag);
    bstart(); wack(AR, 1'b0, tag);
    for (int w = 0; w < nwords; w++) begin
      logic [23:0] e;
      e = (w == 0) ? e0 : e1;
      for (int k = 0; k < 3; k++) begin
        exp_q.push_back(e[23-8*k -: 8]); tag_q.push_back(tag);
        rbyte((w == nwords-1) && (k == 2));
      end
    end
    bstop();
    repeat (4) @(negedge clk);
    chk({tag, " pull released"}, {31'h0, sda_pull}, 32'h0);
  endtask

  initial begin
    int lat0, sync0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset pull", {31'h0, sda_pull}, 0);
    chk("R10 reset avg", {24'h0, avg}, 0);
    chk("R10 reset gain", {30'h0, gain}, 0);
    chk("R10 reset flevel", {28'h0, flevel}, 0);

    // R2 plain write
    wr_reg(8'h02, 24'h0000A5, "R2 write ack");
    chk("R2 avg after write", {24'h0, avg}, 32'hA5);

    // R1 mismatched addresses: NACK, later bytes ignored
    bstart(); wack(8'hB4, 1'b1, "R1 high bits nack");
    wack(8'h02, 1'b1, "R1 ignored"); wack(8'h00, 1'b1, "R1 ignored");
    wack(8'h00, 1'b1, "R1 ignored"); wack(8'h11, 1'b1, "R1 ignored"); bstop();
    bstart(); wack(8'hD6, 1'b1, "R1 strap bits nack"); bstop();
    chk("R1 avg untouched", {24'h0, avg}, 32'hA5);

    // R3 R7 R4 stream: 0x01 ignored, 0x02 written, partial dropped
    bstart(); wack(AW, 1'b0, "R3 stream"); wack(8'h01, 1'b0, "R7 unmapped ack");
    wack(8'h00, 1'b0, "R7 unmapped ack"); wack(8'h00, 1'b0, "R7 unmapped ack");
    wack(8'h77, 1'b0, "R7 unmapped ack");
    wack(8'h00, 1'b0, "R3 stream"); wack(8'h00, 1'b0, "R3 stream"); wack(8'h3C, 1'b0, "R3 stream");
    wack(8'h00, 1'b0, "R4 partial"); wack(8'h00, 1'b0, "R4 partial");
    bstop();
    chk("R3 avg via increment", {24'h0, avg}, 32'h3C);
    chk("R7 gain untouched", {30'h0, gain}, 0);

    // R4 R11 partial ended by repeated START
    bstart(); wack(AW, 1'b0, "R11 write"); wack(8'h06, 1'b0, "R11 write");
    wack(8'h00, 1'b0, "R11 write");
    bstart(); wack(AW, 1'b0, "R11 restart"); wack(8'h06, 1'b0, "R11 restart");
    wack(8'h00, 1'b0, "R11 restart"); wack(8'h00, 1'b0, "R11 restart");
    wack(8'h05, 1'b0, "R11 restart"); bstop();
    chk("R11 flevel aligned after restart", {28'h0, flevel}, 32'h5);

    wr_reg(8'h04, 24'hFFFFFE, "R6 gain write");
    chk("R6 gain field", {30'h0, gain}, 32'h2);

    // R5 R6 reads
    sync0 = sync_cnt;
    rd_regs(8'h02, 24'h00003C, 24'h0, 1, "R6 read avg word");
    rd_regs(8'h03, 24'h000000, 24'h000002, 2, "R5 stream read 0x03 to 0x04");
    rd_regs(8'h06, 24'h000005, 24'h0, 1, "R6 read flevel word");
    chk("R9 no sync pulse off status", sync_cnt - sync0, 0);

    cur = 9'h1A5; fnow = 1'b1; flat = 1'b1; fsync = 1'b1;
    rd_regs(8'h00, 24'h000FA5, 24'h0, 1, "R6 status word");
    chk("R9 one sync pulse", sync_cnt - sync0, 1);
    cur = 9'h003; fnow = 1'b0; flat = 1'b0; fsync = 1'b0;
    rd_regs(8'h00, 24'h000003, 24'h0, 1, "R6 status word low");
    chk("R9 second sync pulse", sync_cnt - sync0, 2);

    // R8 latched clear
    lat0 = lat_cnt;
    wr_reg(8'h00, 24'h000400, "R8 clear write");
    chk("R8 one lat pulse", lat_cnt - lat0, 1);
    wr_reg(8'h00, 24'hFFFBFF, "R8 bit10 clear write");
    chk("R8 no lat pulse", lat_cnt - lat0, 1);
    chk("R8 avg unchanged", {24'h0, avg}, 32'h3C);
    chk("R8 gain unchanged", {30'h0, gain}, 32'h2);
    chk("R8 flevel unchanged", {28'h0, flevel}, 32'h5);

    repeat (20) @(negedge clk);
    chk("R5 all bytes compared", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule